// File: doc/BRIEF.md
# Register Write Coalescing Packer

The packer turns a stream of register-write requests into a compact command buffer held in a local RAM. Every request it emits becomes a two-word instruction that starts on an even word. A write carries a register offset, a 32-bit value and a 32-bit mask. A mask of all ones makes a full write. Any other mask makes a partial write, whose byte enables come from the mask's byte lanes.

Full writes that follow one another to the same offset are coalesced. The first repeat rewrites the single-write instruction that was already emitted into an indexed burst, and each later repeat appends one more value. A no-op request emits empty instructions. A finish request pads the buffer with zeros to a whole number of 16-word lines and freezes it. A consumer reads the finished buffer through a synchronous read port.

Top module: `cmd_packer`

## Requirements
- R1: After reset, `req_ready_o` is 1, `len_o` is 0, and `overflow_o` and `done_o` are 0.
- R2: A full write (mask 0xFFFFFFFF) that cannot merge emits its value at the next even word. It places the word {8'h01, 4'hF, offset[19:0]} right after the value, and `len_o` advances past both words.
- R3: A full write to the same offset as an immediately preceding full single write rewrites that instruction in place. The result is the count word 2, then {8'h09, 4'h0, offset}, then the old value, then the new value. Each further full write to that offset appends its value and increments the count word.
- R4: When an append leaves the word count odd, the word at that position is written with zero. The next instruction then starts at the following even word.
- R5: A partial write emits {8'h01, be, offset}, where bit k of be is set when mask byte k (bits 8k+7:8k) is nonzero. A partial write never merges, and a full write that follows it does not merge into it.
- R6: Merging looks only at the instruction just before. Any other instruction in between, including a no-op, makes the next full write a new single write.
- R7: A no-op request with count n emits n instructions of two zero words each. A count of 0 emits nothing.
- R8: A write or a no-op instruction arriving while `len_o` > DEPTH-2 is refused. The buffer and `len_o` stay unchanged, and `overflow_o` is set and stays set until reset.
- R9: Finish writes zeros from `len_o` up to the next multiple of 16 words. It then sets `len_o` to that length and raises `done_o`. Once `done_o` is high, `req_ready_o` stays 0 and requests have no effect.
- R10: `rd_data_o` shows the buffer word at `rd_addr_i` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Packer can accept a request |
| req_kind_i | input | 2 | 0 write, 1 no-op, 2 finish |
| req_off_i | input | 20 | Register offset |
| req_val_i | input | 32 | Write value |
| req_mask_i | input | 32 | Write mask |
| req_cnt_i | input | CNT_W | No-op instruction count |
| rd_addr_i | input | log2(DEPTH) | Buffer read address |
| rd_data_o | output | 32 | Buffer read data, one cycle later |
| len_o | output | log2(DEPTH)+1 | Words used; after finish the aligned length |
| overflow_o | output | 1 | Sticky refusal flag |
| done_o | output | 1 | Buffer finished |

## Verification
An accepted request keeps the packer busy for a number of cycles that depends on the request. A single write takes two cycles and a rewrite into a burst takes four. An append takes two cycles, or three when it also writes a pad word. Each no-op instruction takes two cycles, and each fill word during finish takes one. A refused request returns `req_ready_o` high on the very next cycle. For these reasons the bench does not count cycles after each request. It waits at the falling edge for `req_ready_o`, or for `done_o` after a finish, and only then samples `len_o` and the flags. Read data is due one cycle after the address. The monitor therefore compares the word at the falling edge that follows the rising edge which captured the address.

// File: rtl/cmd_packer_pkg.sv
package cmd_packer_pkg;
  localparam int OFF_W = 20;
  localparam logic [7:0] OP_SINGLE = 8'h01;
  localparam logic [7:0] OP_BURST  = 8'h09;

  typedef enum logic [1:0] {
    REQ_WRITE  = 2'd0,
    REQ_NOOP   = 2'd1,
    REQ_FINISH = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    LAST_NONE,
    LAST_SINGLE,
    LAST_BURST,
    LAST_OTHER
  } last_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SGL, S_CONV, S_APP, S_NOP, S_FILL, S_DONE
  } state_e;
endpackage

// File: rtl/cmd_packer_enc.sv
module cmd_packer_enc
  import cmd_packer_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [31:0]      mask_i,
  output logic [31:0]      single_hi_o,
  output logic             full_o
);
  logic [3:0] be;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign be[k] = |mask_i[8*k +: 8];
  end

  assign full_o      = &mask_i;
  assign single_hi_o = {OP_SINGLE, be, off_i};
endmodule

// File: rtl/cmd_packer_ram.sv
module cmd_packer_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cmd_packer_ctrl.sv
module cmd_packer_ctrl
  import cmd_packer_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 16,
  parameter int CNT_W      = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [31:0]      req_val_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic [31:0]      single_hi_i,
  input  logic             full_i,
  output logic             req_ready_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [31:0]      wdata_o,
  output logic [PW-1:0]    len_o,
  output logic             overflow_o,
  output logic             done_o
);
  localparam int LB = $clog2(LINE_WORDS);
  localparam logic [PW-1:0] ROOM_MAX = PW'(DEPTH - 2);

  state_e           state_q;
  last_e            last_q;
  logic [PW-1:0]    free_q, ins_q, start_w, wptr;
  logic [OFF_W-1:0] last_off_q;
  logic [31:0]      last_val_q, val_q, hi_q, bcnt_q;
  logic             full_q, ovf_q, done_q, room_w, same_w;
  logic [1:0]       step_q;
  logic [CNT_W-1:0] nop_left_q;

  // next even position for a fresh instruction
  assign start_w = free_q + PW'(free_q[0]);
  assign room_w  = free_q <= ROOM_MAX;
  assign same_w  = req_off_i == last_off_q;

  assign req_ready_o = (state_q == S_IDLE);
  assign len_o       = free_q;
  assign overflow_o  = ovf_q;
  assign done_o      = done_q;
  assign waddr_o     = wptr[AW-1:0];

  always_comb begin
    we_o    = 1'b0;
    wptr    = '0;
    wdata_o = '0;
    unique case (state_q)
      S_SGL: begin
        we_o    = 1'b1;
        wptr    = step_q[0] ? start_w + PW'(1) : start_w;
        wdata_o = step_q[0] ? hi_q : val_q;
      end
      S_CONV: begin
        we_o = 1'b1;
        wptr = ins_q + PW'(step_q);
        case (step_q)
          2'd0:    wdata_o = 32'd2;
          2'd1:    wdata_o = {OP_BURST, 4'h0, last_off_q};
          2'd2:    wdata_o = last_val_q;
          default: wdata_o = val_q;
        endcase
      end
      S_APP: begin
        we_o = 1'b1;
        case (step_q)
          2'd0:    begin wptr = free_q; wdata_o = val_q; end
          2'd1:    begin wptr = ins_q;  wdata_o = bcnt_q + 32'd1; end
          default: begin wptr = free_q; wdata_o = '0; end
        endcase
      end
      S_NOP: begin
        we_o = room_w;
        wptr = start_w + PW'(step_q[0]);
      end
      S_FILL: begin
        we_o = |free_q[LB-1:0];
        wptr = free_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      last_q     <= LAST_NONE;
      free_q     <= '0;
      ins_q      <= '0;
      last_off_q <= '0;
      last_val_q <= '0;
      val_q      <= '0;
      hi_q       <= '0;
      bcnt_q     <= '0;
      full_q     <= 1'b0;
      ovf_q      <= 1'b0;
      done_q     <= 1'b0;
      step_q     <= '0;
      nop_left_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          val_q  <= req_val_i;
          hi_q   <= single_hi_i;
          full_q <= full_i;
          step_q <= '0;
          case (req_kind_i)
            REQ_WRITE: begin
              if (!room_w) ovf_q <= 1'b1;
              else if (full_i && same_w && last_q == LAST_SINGLE) state_q <= S_CONV;
              else if (full_i && same_w && last_q == LAST_BURST)  state_q <= S_APP;
              else begin
                state_q    <= S_SGL;
                last_off_q <= req_off_i;
              end
            end
            REQ_NOOP: if (req_cnt_i != '0) begin
              nop_left_q <= req_cnt_i;
              state_q    <= S_NOP;
            end
            REQ_FINISH: begin
              last_q  <= LAST_OTHER;
              state_q <= S_FILL;
            end
            default: ;
          endcase
        end
        S_SGL: begin
          step_q <= step_q + 2'd1;
          if (step_q[0]) begin
            free_q     <= start_w + PW'(2);
            ins_q      <= start_w;
            last_q     <= full_q ? LAST_SINGLE : LAST_OTHER;
            last_val_q <= val_q;
            state_q    <= S_IDLE;
          end
        end
        S_CONV: begin
          step_q <= step_q + 2'd1;
          if (step_q == 2'd3) begin
            free_q  <= ins_q + PW'(4);
            bcnt_q  <= 32'd2;
            last_q  <= LAST_BURST;
            state_q <= S_IDLE;
          end
        end
        S_APP: begin
          step_q <= step_q + 2'd1;
          case (step_q)
            2'd0: free_q <= free_q + PW'(1);
            2'd1: begin
              bcnt_q <= bcnt_q + 32'd1;
              if (!free_q[0]) state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
          endcase
        end
        S_NOP: begin
          if (!room_w || step_q[0]) begin
            nop_left_q <= nop_left_q - CNT_W'(1);
            step_q     <= '0;
            if (nop_left_q == CNT_W'(1)) state_q <= S_IDLE;
          end else begin
            step_q <= 2'd1;
          end
          if (!room_w) ovf_q <= 1'b1;
          else if (step_q[0]) begin
            free_q <= start_w + PW'(2);
            ins_q  <= start_w;
            last_q <= LAST_OTHER;
          end
        end
        S_FILL: begin
          if (|free_q[LB-1:0]) free_q <= free_q + PW'(1);
          else begin
            done_q  <= 1'b1;
            state_q <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmd_packer_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 16,
  parameter int CNT_W      = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic [19:0]      req_off_i,
  input  logic [31:0]      req_val_i,
  input  logic [31:0]      req_mask_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [31:0]      rd_data_o,
  output logic [AW:0]      len_o,
  output logic             overflow_o,
  output logic             done_o
);
  logic [31:0]   single_hi;
  logic          full;
  logic          we;
  logic [AW-1:0] waddr;
  logic [31:0]   wdata;

  cmd_packer_enc u_enc (
    .off_i       (req_off_i),
    .mask_i      (req_mask_i),
    .single_hi_o (single_hi),
    .full_o      (full)
  );

  cmd_packer_ctrl #(
    .DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_off_i   (req_off_i),
    .req_val_i   (req_val_i),
    .req_cnt_i   (req_cnt_i),
    .single_hi_i (single_hi),
    .full_i      (full),
    .req_ready_o (req_ready_o),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .len_o       (len_o),
    .overflow_o  (overflow_o),
    .done_o      (done_o)
  );

  cmd_packer_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [1:0]  req_kind_i,
  input logic [AW:0] len_o,
  input logic        overflow_o,
  input logic        done_o
);
  localparam logic [AW:0] ROOM_MAX = (AW+1)'(DEPTH - 2);
  localparam logic [AW:0] LMASK    = (AW+1)'(LINE_WORDS - 1);

  a_r1_ready_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_ready_o);

  a_r8_refused_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && req_kind_i == 2'd0 && len_o > ROOM_MAX)
    |=> (len_o == $past(len_o)) && overflow_o);

  a_r8_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r2_len_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(len_o) |-> len_o > $past(len_o));

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(len_o));

  a_r9_not_ready_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o);

  a_r9_len_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (len_o & LMASK) == '0);
endmodule

bind cmd_packer cmd_packer_chk #(.DEPTH(DEPTH), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_kind_i  (req_kind_i),
  .len_o       (len_o),
  .overflow_o  (overflow_o),
  .done_o      (done_o)
);

// File: tb/cmd_packer_bench.sv
`timescale 1ns/1ps
module cmd_packer_bench;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [19:0]   req_off = '0;
  logic [31:0]   req_val = '0;
  logic [31:0]   req_mask = '0;
  logic [7:0]    req_cnt = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [AW:0]   len;
  logic          ovf, done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t        q[$];
  logic [31:0] exp_mem [DEPTH];
  logic        rd_req = 1'b0;
  logic        rd_pend = 1'b0;

  always #2 clk = ~clk;

  cmd_packer u_cmd_packer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_off_i(req_off), .req_val_i(req_val),
    .req_mask_i(req_mask), .req_cnt_i(req_cnt), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .len_o(len), .overflow_o(ovf), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one cycle after the address
  always @(posedge clk) rd_pend <= rd_req;
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      e = q.pop_front();
      chk(rd_data === e.d, e.tag, rd_data, e.d);
    end
  end

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(len === '0, "R1 len", 32'(len), 32'd0);
    chk(ovf === 1'b0 && done === 1'b0, "R1 flags", {30'd0, ovf, done}, 32'd0);
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
  endtask

  task automatic send(input logic [1:0] kind, input logic [19:0] off,
                      input logic [31:0] val, input logic [31:0] mask, input logic [7:0] cnt);
    @(negedge clk);
    req_kind = kind; req_off = off; req_val = val; req_mask = mask; req_cnt = cnt;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && !done) @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] off, input logic [31:0] val, input logic [31:0] mask);
    send(2'd0, off, val, mask, 8'd0);
  endtask

  task automatic finish_buf(input int exp_len, input string tag);
    send(2'd2, '0, '0, '0, 8'd0);
    while (!done) @(negedge clk);
    chk(len === (AW+1)'(exp_len), {tag, " len after finish"}, 32'(len), 32'(exp_len));
    chk(req_ready === 1'b0, "R9 ready low when done", 32'(req_ready), 32'd0);
  endtask

  task automatic readback(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_addr = AW'(i);
      rd_req = 1'b1;
      q.push_back('{exp_mem[i], $sformatf("%s word %0d", tag, i)});
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Scenario A: merge, pad, partial write, no-op break
    do_reset();
    wr(20'h123, 32'hA000_0001, FULL);
    chk(len === 7'd2, "R2 single len", 32'(len), 32'd2);
    wr(20'h123, 32'hA000_0002, FULL);
    chk(len === 7'd4, "R3 merge len", 32'(len), 32'd4);
    wr(20'h123, 32'hA000_0003, FULL);
    chk(len === 7'd5, "R4 odd len after append", 32'(len), 32'd5);
    wr(20'h040, 32'hB000_0001, 32'h00FF_0000);
    chk(len === 7'd8, "R4 next instruction on even word", 32'(len), 32'd8);
    wr(20'h040, 32'hB000_0002, FULL);
    send(2'd1, '0, '0, '0, 8'd2);
    chk(len === 7'd14, "R7 noop len", 32'(len), 32'd14);
    wr(20'h040, 32'hB000_0003, FULL);
    wr(20'h040, 32'hB000_0004, FULL);
    exp_mem[0]  = 32'd3;          exp_mem[1]  = 32'h0900_0123;
    exp_mem[2]  = 32'hA000_0001;  exp_mem[3]  = 32'hA000_0002;
    exp_mem[4]  = 32'hA000_0003;  exp_mem[5]  = 32'h0;
    exp_mem[6]  = 32'hB000_0001;  exp_mem[7]  = 32'h0140_0040;
    exp_mem[8]  = 32'hB000_0002;  exp_mem[9]  = 32'h01F0_0040;
    exp_mem[14] = 32'd2;          exp_mem[15] = 32'h0900_0040;
    exp_mem[16] = 32'hB000_0003;  exp_mem[17] = 32'hB000_0004;
    finish_buf(32, "R9 A");
    readback(32, "R3 R4 R5 R6 R7 R9 R10 A");

    // Scenario B: partial writes never merge; burst of two; merge only on predecessor
    do_reset();
    wr(20'h0AB, 32'hC000_0000, 32'hFFFF_FF00);
    wr(20'h0AB, 32'hC000_0001, 32'h0100_0001);
    wr(20'h0AB, 32'hC000_0002, FULL);
    wr(20'h0AB, 32'hC000_0003, FULL);
    chk(len === 7'd8, "R3 burst of two even len", 32'(len), 32'd8);
    send(2'd1, '0, '0, '0, 8'd0);
    chk(len === 7'd8, "R7 noop count zero", 32'(len), 32'd8);
    wr(20'h0CD, 32'hD000_0000, FULL);
    wr(20'h0AB, 32'hC000_0004, FULL);
    exp_mem[0]  = 32'hC000_0000;  exp_mem[1]  = 32'h01E0_00AB;
    exp_mem[2]  = 32'hC000_0001;  exp_mem[3]  = 32'h0190_00AB;
    exp_mem[4]  = 32'd2;          exp_mem[5]  = 32'h0900_00AB;
    exp_mem[6]  = 32'hC000_0002;  exp_mem[7]  = 32'hC000_0003;
    exp_mem[8]  = 32'hD000_0000;  exp_mem[9]  = 32'h01F0_00CD;
    exp_mem[10] = 32'hC000_0004;  exp_mem[11] = 32'h01F0_00AB;
    finish_buf(16, "R9 B");
    readback(16, "R2 R5 R6 B");

    // Scenario C: fill to capacity, then refusals
    do_reset();
    for (int i = 0; i < DEPTH / 2; i++) begin
      wr(20'h100 + 20'(i), 32'h5A00_0000 + 32'(i), FULL);
      exp_mem[2*i]   = 32'h5A00_0000 + 32'(i);
      exp_mem[2*i+1] = 32'h01F0_0100 + 32'(i);
    end
    chk(len === 7'(DEPTH) && ovf === 1'b0, "R8 full without overflow", {24'd0, ovf, len}, 32'(DEPTH));
    wr(20'h200, 32'hEEEE_0000, FULL);
    chk(ovf === 1'b1, "R8 overflow set", 32'(ovf), 32'd1);
    chk(len === 7'(DEPTH), "R8 len unchanged", 32'(len), 32'(DEPTH));
    wr(20'h11F, 32'hEEEE_0001, FULL);
    send(2'd1, '0, '0, '0, 8'd1);
    chk(len === 7'(DEPTH) && ovf === 1'b1, "R8 merge and noop refused", {24'd0, ovf, len}, 32'h80 | 32'(DEPTH));
    finish_buf(DEPTH, "R9 C");
    readback(DEPTH, "R8 C");

    // Scenario D: empty finish, requests ignored afterwards
    do_reset();
    finish_buf(0, "R9 D");
    @(negedge clk);
    req_kind = 2'd0; req_off = 20'h1; req_val = 32'h1; req_mask = FULL; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    chk(len === '0 && done === 1'b1, "R9 request after done ignored", {24'd0, done, len}, 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule